// File: doc/BRIEF.md
# Timed Heater Test Sequencer

This block runs a fixed thermal experiment on its own once a start pulse arrives. The experiment has four phases of equal length, counted in clock ticks. The order is: a settle phase with the heater off, a heating phase, a cooling phase with the heater off, and a second heating phase. A heater enable output follows the active phase. A separate sampling timer runs over the whole experiment. Each time it expires, the block takes the temperature word from its input and sends one framed record to a host over an 8N1 serial line.

Each record is four bytes long: a sync marker, the phase index, then the temperature high byte and low byte. If the sensor does not flag its word as valid at the sampling instant, the block sends the last value it captured again. When the fourth phase ends, the heater switches off and `done` goes high. `done` stays high until another start pulse arrives.

Top module: `thermal_profile_seq`

## Requirements
- R1: A start pulse seen while not running begins phase 0 on the next cycle. Phases then advance 0, 1, 2, 3, and each lasts PHASE_TICKS cycles. `phaseOut` shows the active phase index and reads 0 when not running.
- R2: `heaterEn` is high exactly while phase 1 or phase 3 is active, and low at all other times.
- R3: A start pulse that arrives while a run is in progress has no effect on the phase sequence.
- R4: A sample is taken every SAMPLE_TICKS cycles after the start, up to and including the cycle that ends phase 3. The phase byte carries the phase that was active in the sampling cycle.
- R5: When phase 3 ends, `done` goes high with `heaterEn` low. It stays high until the next start pulse, which clears it.
- R6: Each byte goes out as a low start bit, eight data bits LSB first, then a high stop bit. Every bit lasts CLKS_PER_BIT cycles. The bytes of a record follow each other with no gap. The line idles high, and a new record never begins while one is still being sent.
- R7: A record is four bytes in this order: 0xA5; the phase index in bits 1:0 with bits 7:2 zero; temperature bits 15:8; temperature bits 7:0.
- R8: When `tempValid` is low at a sampling instant, the record carries the previously captured temperature. The captured value resets to 0 and is kept from one run to the next.
- R9: Reset puts the block in the idle state: heater off, `done` low, phase 0 and the serial line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, takes effect only when not running |
| tempWord | input | 16 | Temperature reading from the sensor |
| tempValid | input | 1 | Marks `tempWord` as fresh |
| heaterEn | output | 1 | Heater enable |
| phaseOut | output | 2 | Active phase index |
| done | output | 1 | Experiment finished |
| txLine | output | 1 | Serial output, idles high |

## Verification
The bench builds the block with PHASE_TICKS=600, SAMPLE_TICKS=200 and CLKS_PER_BIT=4. This gives three samples per phase, and one sample lands exactly on the cycle that closes each phase. That puts the phase-boundary attribution and the final sample, which is taken as `done` rises, within a run of about 2,400 cycles. A four-byte record takes 160 cycles, so every record finishes before the next sample is due. The bench decodes every record bit by bit. It also drives a table of valid and invalid readings so that the resend path is hit several times, and it covers a second run after `done`.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int TEMP_W = 16;
  localparam int NUM_PHASES = 4;
  localparam int BYTES_PER_REC = 4;
  localparam int BITS_PER_CHAR = 10;

  // strobes from control to datapath
  typedef struct packed {
    logic       sampleStb;
    logic [1:0] phase;
  } ctrlStb_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int PHASE_TICKS  = 1000,
  parameter int SAMPLE_TICKS = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       frameBusy,
  output ctrlStb_t   ctrlStb,
  output logic       heaterEn,
  output logic [1:0] phaseOut,
  output logic       done
);
  localparam int PW = $clog2(PHASE_TICKS + 1);
  localparam int SW = $clog2(SAMPLE_TICKS + 1);
  localparam logic [PW-1:0] PHASE_LAST  = PW'(PHASE_TICKS - 1);
  localparam logic [SW-1:0] SAMPLE_LAST = SW'(SAMPLE_TICKS - 1);
  localparam logic [1:0]    FINAL_PHASE = 2'(NUM_PHASES - 1);

  logic          running;
  logic [1:0]    phase;
  logic [PW-1:0] phaseCnt;
  logic [SW-1:0] sampleCnt;
  logic          doneR;
  logic          sampleWrap;
  logic          phaseWrap;

  assign sampleWrap = (sampleCnt == SAMPLE_LAST);
  assign phaseWrap  = (phaseCnt == PHASE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      phase     <= '0;
      phaseCnt  <= '0;
      sampleCnt <= '0;
      doneR     <= 1'b0;
    end else if (!running) begin
      if (start) begin
        running   <= 1'b1;
        phase     <= '0;
        phaseCnt  <= '0;
        sampleCnt <= '0;
        doneR     <= 1'b0;
      end
    end else begin
      sampleCnt <= sampleWrap ? '0 : sampleCnt + 1'b1;
      if (phaseWrap) begin
        phaseCnt <= '0;
        if (phase == FINAL_PHASE) begin
          running <= 1'b0;
          doneR   <= 1'b1;
          phase   <= '0;
        end else begin
          phase <= phase + 1'b1;
        end
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  assign ctrlStb.sampleStb = running && sampleWrap && !frameBusy;
  assign ctrlStb.phase     = phase;
  assign heaterEn          = running && phase[0];
  assign phaseOut          = phase;
  assign done              = doneR;
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int         CLKS_PER_BIT = 868,
  parameter logic [7:0] SYNC_BYTE    = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          ctrlStb,
  input  logic [TEMP_W-1:0] tempWord,
  input  logic              tempValid,
  output logic              frameBusy,
  output logic              txLine
);
  localparam int BW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [BW-1:0] BAUD_LAST = BW'(CLKS_PER_BIT - 1);
  localparam logic [3:0]    BIT_LAST  = 4'(BITS_PER_CHAR - 1);
  localparam logic [1:0]    BYTE_LAST = 2'(BYTES_PER_REC - 1);

  logic [TEMP_W-1:0]        heldTemp;
  logic [1:0]               recPhase;
  logic [1:0]               byteIdx;
  logic [3:0]               bitIdx;
  logic [BW-1:0]            baudCnt;
  logic [BITS_PER_CHAR-1:0] shifter;
  logic                     busy;
  logic [7:0]               nextByte;

  // byte that follows the one currently on the line
  always_comb begin
    unique case (byteIdx)
      2'd0:    nextByte = {6'b0, recPhase};
      2'd1:    nextByte = heldTemp[15:8];
      default: nextByte = heldTemp[7:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldTemp <= '0;
      recPhase <= '0;
      byteIdx  <= '0;
      bitIdx   <= '0;
      baudCnt  <= '0;
      shifter  <= '1;
      busy     <= 1'b0;
    end else if (!busy) begin
      if (ctrlStb.sampleStb) begin
        if (tempValid) heldTemp <= tempWord;
        recPhase <= ctrlStb.phase;
        byteIdx  <= '0;
        bitIdx   <= '0;
        baudCnt  <= '0;
        shifter  <= {1'b1, SYNC_BYTE, 1'b0};
        busy     <= 1'b1;
      end
    end else if (baudCnt == BAUD_LAST) begin
      baudCnt <= '0;
      if (bitIdx == BIT_LAST) begin
        bitIdx <= '0;
        if (byteIdx == BYTE_LAST) begin
          busy    <= 1'b0;
          shifter <= '1;
        end else begin
          byteIdx <= byteIdx + 1'b1;
          shifter <= {1'b1, nextByte, 1'b0};
        end
      end else begin
        bitIdx  <= bitIdx + 1'b1;
        shifter <= {1'b1, shifter[BITS_PER_CHAR-1:1]};
      end
    end else begin
      baudCnt <= baudCnt + 1'b1;
    end
  end

  assign frameBusy = busy;
  assign txLine    = busy ? shifter[0] : 1'b1;
endmodule

// File: rtl/thermal_profile_seq.sv
module thermal_profile_seq
  import seq_pkg::*;
#(
  parameter int PHASE_TICKS  = 70_000_000,
  parameter int SAMPLE_TICKS = 100_000_000,
  parameter int CLKS_PER_BIT = 868
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [15:0] tempWord,
  input  logic        tempValid,
  output logic        heaterEn,
  output logic [1:0]  phaseOut,
  output logic        done,
  output logic        txLine
);
  ctrlStb_t ctrlStb;
  logic     frameBusy;

  seq_ctrl #(
    .PHASE_TICKS (PHASE_TICKS),
    .SAMPLE_TICKS(SAMPLE_TICKS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .frameBusy(frameBusy),
    .ctrlStb  (ctrlStb),
    .heaterEn (heaterEn),
    .phaseOut (phaseOut),
    .done     (done)
  );

  seq_datapath #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .SYNC_BYTE   (8'hA5)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlStb  (ctrlStb),
    .tempWord (tempWord),
    .tempValid(tempValid),
    .frameBusy(frameBusy),
    .txLine   (txLine)
  );
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       heaterEn,
  input logic [1:0] phaseOut,
  input logic       done,
  input logic       txLine,
  input logic       sampleStb
);
  p_heat_odd_phase_r2: assert property (@(posedge clk) disable iff (!rstN)
    heaterEn |-> phaseOut[0]);

  p_done_heater_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !heaterEn);

  p_phase_order_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(phaseOut) |-> ((phaseOut == 2'($past(phaseOut) + 2'd1)) ||
                            (phaseOut == 2'd0 && $past(phaseOut) == 2'd3)));

  p_done_after_reheat_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(phaseOut) == 2'd3 && $past(heaterEn)));

  p_start_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> !txLine);

  // R9: line held high while in reset
  always @(negedge clk) begin
    if (rstN === 1'b0) begin
      p_reset_line_r9: assert (txLine === 1'b1 && heaterEn === 1'b0);
    end
  end
endmodule

bind thermal_profile_seq seq_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .heaterEn (heaterEn),
  .phaseOut (phaseOut),
  .done     (done),
  .txLine   (txLine),
  .sampleStb(ctrlStb.sampleStb)
);

// File: tb/thermal_profile_seq_tb_top.sv
`timescale 1ns/1ps
module thermal_profile_seq_tb_top;
  localparam int PT  = 600;
  localparam int ST  = 200;
  localparam int CPB = 4;
  localparam int RUN = 4 * PT;
  localparam int NS  = RUN / ST;

  // {valid, temperature} driven around each sampling instant
  localparam logic [16:0] SAMPLE_TBL [12] = '{
    {1'b1, 16'h0123}, {1'b1, 16'h0456}, {1'b0, 16'hDEAD}, {1'b1, 16'h1A2B},
    {1'b1, 16'h00FF}, {1'b0, 16'hBEEF}, {1'b1, 16'h8000}, {1'b1, 16'h7FFF},
    {1'b0, 16'h5555}, {1'b1, 16'hFFFF}, {1'b1, 16'h0001}, {1'b0, 16'hCAFE}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] tempWord = '0;
  logic        tempValid = 1'b0;
  logic        heaterEn, done, txLine;
  logic [1:0]  phaseOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] rxBytes [0:127];
  int rxCount = 0;
  int framingErr = 0;

  always #2.5 clk = ~clk;

  thermal_profile_seq #(
    .PHASE_TICKS (PT),
    .SAMPLE_TICKS(ST),
    .CLKS_PER_BIT(CPB)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .tempWord(tempWord),
    .tempValid(tempValid), .heaterEn(heaterEn), .phaseOut(phaseOut),
    .done(done), .txLine(txLine)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // serial receiver, samples mid-bit on falling clock edges
  initial begin
    forever begin
      @(negedge clk);
      if (rstN === 1'b1 && txLine === 1'b0) begin
        logic [7:0] b;
        repeat (CPB / 2) @(negedge clk);
        if (txLine !== 1'b0) framingErr++;
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = txLine;
        end
        repeat (CPB) @(negedge clk);
        if (txLine !== 1'b1) framingErr++;
        if (rxCount < 128) rxBytes[rxCount] = b;
        rxCount++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    int expPhase;
    // reset state (R9)
    repeat (3) @(negedge clk);
    chk("R9", "heaterEn in reset", heaterEn, 0);
    chk("R9", "txLine in reset", txLine, 1);
    chk("R9", "done in reset", done, 0);
    chk("R9", "phaseOut in reset", phaseOut, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "phase idle", phaseOut, 0);

    // run 1
    start = 1'b1;
    @(negedge clk);
    for (int n = 0; n < RUN + 200; n++) begin
      start = (n == 700);  // R3: pulse mid-run
      if (n < RUN) begin
        tempWord  = SAMPLE_TBL[n / ST][15:0];
        tempValid = SAMPLE_TBL[n / ST][16];
      end
      if (n < RUN && (n % PT == 0 || n % PT == PT - 1)) begin
        chk("R1", "phase index", phaseOut, n / PT);
        chk("R2", "heater per phase", heaterEn, (n / PT) % 2);
      end
      if (n == 701) chk("R3", "start ignored mid-run", phaseOut, 1);
      if (n == RUN - 1) chk("R5", "done before end", done, 0);
      if (n == RUN) begin
        chk("R5", "done at end", done, 1);
        chk("R5", "heater off at end", heaterEn, 0);
        chk("R1", "phase idle after run", phaseOut, 0);
      end
      @(negedge clk);
    end
    chk("R4", "record byte count", rxCount, NS * 4);
    chk("R6", "framing errors", framingErr, 0);
    chk("R5", "done held", done, 1);

    // walk expected records from the table
    held = 16'h0000;
    for (int k = 0; k < NS; k++) begin
      if (SAMPLE_TBL[k][16]) held = SAMPLE_TBL[k][15:0];
      expPhase = ((k + 1) * ST - 1) / PT;
      chk("R7", "sync byte", rxBytes[4*k], 8'hA5);
      chk("R4", "phase byte", rxBytes[4*k+1], expPhase);
      chk("R8", "temp high", rxBytes[4*k+2], held[15:8]);
      chk("R8", "temp low", rxBytes[4*k+3], held[7:0]);
    end

    // run 2 after done
    tempWord = 16'h4242;
    tempValid = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R5", "done cleared by start", done, 0);
    chk("R1", "restart phase 0", phaseOut, 0);
    chk("R2", "heater off in settle", heaterEn, 0);
    for (int n = 1; n < 380; n++) @(negedge clk);
    chk("R4", "run2 byte count", rxCount, NS * 4 + 4);
    chk("R7", "run2 sync", rxBytes[NS*4], 8'hA5);
    chk("R4", "run2 phase", rxBytes[NS*4+1], 0);
    chk("R7", "run2 temp high", rxBytes[NS*4+2], 8'h42);
    chk("R7", "run2 temp low", rxBytes[NS*4+3], 8'h42);

    // reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    chk("R9", "heater after reset", heaterEn, 0);
    chk("R9", "line after reset", txLine, 1);
    chk("R9", "phase after reset", phaseOut, 0);
    chk("R9", "done after reset", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule